// File: doc/BRIEF.md
# Iterative Integer Multiplier With Overflow Trap Flag

This block is a sequential 64 by 64 bit integer multiplier for an execution pipeline. A caller presents a function code and two operands with a one-cycle start strobe. The unit then works through the multiplier one bit per cycle with a shift-and-add engine. When it finishes it pulses done for one cycle, and in that cycle the result, an overflow flag and an illegal-function flag are valid. Outputs hold their values until the next completion.

One unsigned engine serves every function. It can return the low 32 bits of a 32 by 32 product, the low 64 bits of the full product, or the upper 64 bits of the unsigned 128-bit product. Two checking variants report signed overflow. For these, a small resolve stage turns the unsigned high half into the signed high half by subtracting each operand wherever the other operand is negative. It then tests whether the bits above the kept result are only a copy of its sign bit. An unknown function code does not start the engine. It completes on the next cycle with the illegal flag set.

Top module: `mul_trap_unit`

## Requirements
- R1: After reset, done, result, overflow and illegal are all zero.
- R2: Function 7'h00 multiplies bits 31:0 of each operand and returns bits 31:0 of the product, sign-extended to 64 bits. Operand bits 63:32 have no effect.
- R3: Function 7'h20 returns bits 63:0 of the 64 by 64 product.
- R4: Function 7'h30 returns bits 127:64 of the unsigned 128-bit product.
- R5: Function 7'h40 sign-extends bits 31:0 of both operands and forms a 64-bit signed product. The result is its bits 31:0, sign-extended. Overflow is set unless product bits 63:31 are all zeros or all ones.
- R6: Function 7'h60 returns bits 63:0 of the signed product. Overflow is set unless the signed high 64 bits equal 64 copies of result bit 63.
- R7: A legal function accepted at a clock edge raises done for exactly one cycle, 65 edges later.
- R8: A function code outside {7'h00, 7'h20, 7'h30, 7'h40, 7'h60} raises done at the next edge with illegal = 1, result = 0 and overflow = 0.
- R9: Start is accepted only while no legal operation is in flight. A start during one is ignored: it produces no extra done and leaves the pending result unchanged.
- R10: Overflow is always zero for functions 7'h00, 7'h20 and 7'h30, even when their products exceed the returned width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| func | input | 7 | Function code |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Result, valid with done |
| ovf | output | 1 | Signed overflow detected |
| ill | output | 1 | Function code not recognised |

## Verification
The bench targets the signed high-half correction for function 7'h60. Products of exactly -2^63 must not trap, while +2^63 and large mixed-sign products must trap. A design that skipped the correction, or subtracted the wrong operand, would flag -1 times -1 or miss the +2^63 case. For function 7'h40 it uses boundaries on bit 31 of the product. For the 32-bit functions it puts junk in operand bits 63:32, which a design that failed to sign-extend the inputs would let into the result. Back-to-back illegal codes, and a start issued during a running operation, expose a unit that accepts work while busy or misses the completion cycle by one.

// File: rtl/mul_trap_pkg.sv
package mul_trap_pkg;

   typedef enum logic [2:0] {
      OP_MUL32  = 3'd0,
      OP_MUL64  = 3'd1,
      OP_UMULH  = 3'd2,
      OP_MUL32V = 3'd3,
      OP_MUL64V = 3'd4,
      OP_BAD    = 3'd5
   } mop_e;

   localparam int unsigned FN_BITS = 7;

   localparam logic [FN_BITS-1:0] FN_MUL32  = 7'h00;
   localparam logic [FN_BITS-1:0] FN_MUL64  = 7'h20;
   localparam logic [FN_BITS-1:0] FN_UMULH  = 7'h30;
   localparam logic [FN_BITS-1:0] FN_MUL32V = 7'h40;
   localparam logic [FN_BITS-1:0] FN_MUL64V = 7'h60;

   function automatic mop_e decode_fn(input logic [FN_BITS-1:0] f);
      mop_e r;
      case (f)
         FN_MUL32:  r = OP_MUL32;
         FN_MUL64:  r = OP_MUL64;
         FN_UMULH:  r = OP_UMULH;
         FN_MUL32V: r = OP_MUL32V;
         FN_MUL64V: r = OP_MUL64V;
         default:   r = OP_BAD;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mul_trap_engine.sv
module mul_trap_engine #(
   parameter int unsigned W = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [W-1:0]   mcand_in,
   input  logic [W-1:0]   mplier_in,
   output logic           fin,
   output logic [2*W-1:0] prod
);
   localparam int unsigned CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [W-1:0]  hi_q, lo_q, mcand_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, fin_q;
   logic [W:0]    sum;

   always_comb begin
      sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         lo_q    <= '0;
         mcand_q <= '0;
         cnt_q   <= '0;
         run_q   <= 1'b0;
         fin_q   <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (load) begin
            hi_q    <= '0;
            lo_q    <= mplier_in;
            mcand_q <= mcand_in;
            cnt_q   <= '0;
            run_q   <= 1'b1;
         end else if (run_q) begin
            hi_q  <= sum[W:1];
            lo_q  <= {sum[0], lo_q[W-1:1]};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign fin  = fin_q;
   assign prod = {hi_q, lo_q};

endmodule

// File: rtl/mul_trap_resolve.sv
module mul_trap_resolve
   import mul_trap_pkg::*;
#(
   parameter int unsigned W = 64
) (
   input  mop_e           op,
   input  logic [2*W-1:0] prod,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   res,
   output logic           ovf
);
   localparam int unsigned H = W / 2;

   logic [W-1:0]   p_lo, p_hi, hi_s, half_sx;
   logic [W-H:0]   top_bits;

   always_comb begin
      p_lo     = prod[W-1:0];
      p_hi     = prod[2*W-1:W];
      hi_s     = p_hi - (a[W-1] ? b : '0) - (b[W-1] ? a : '0);
      half_sx  = {{(W-H){p_lo[H-1]}}, p_lo[H-1:0]};
      top_bits = p_lo[W-1:H-1];
      res      = '0;
      ovf      = 1'b0;
      case (op)
         OP_MUL32:  res = half_sx;
         OP_MUL64:  res = p_lo;
         OP_UMULH:  res = p_hi;
         OP_MUL32V: begin
            res = half_sx;
            ovf = !((&top_bits) || !(|top_bits));
         end
         OP_MUL64V: begin
            res = p_lo;
            ovf = (hi_s != {W{p_lo[W-1]}});
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mul_trap_unit.sv
module mul_trap_unit
   import mul_trap_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned FUNC_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FUNC_W-1:0] func,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              ovf,
   output logic              ill
);
   localparam int unsigned HALF_W = DATA_W / 2;

   if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("mul_trap_unit: DATA_W must be even and at least 8");
   end
   if (FUNC_W != FN_BITS) begin : g_bad_func
      $error("mul_trap_unit: FUNC_W must match the function code width");
   end

   mop_e              op_d, op_q;
   logic              legal, accept, busy_q;
   logic              eng_fin;
   logic [DATA_W-1:0] a_ld, b_ld, opa_q, opb_q;
   logic [DATA_W-1:0] fin_res;
   logic              fin_ovf;
   logic [2*DATA_W-1:0] eng_prod;
   logic              done_q, ovf_q, ill_q;
   logic [DATA_W-1:0] res_q;

   always_comb begin
      op_d   = decode_fn(func);
      legal  = (op_d != OP_BAD);
      accept = start && !busy_q;
      if (op_d == OP_MUL32 || op_d == OP_MUL32V) begin
         a_ld = {{(DATA_W-HALF_W){opa[HALF_W-1]}}, opa[HALF_W-1:0]};
         b_ld = {{(DATA_W-HALF_W){opb[HALF_W-1]}}, opb[HALF_W-1:0]};
      end else begin
         a_ld = opa;
         b_ld = opb;
      end
   end

   mul_trap_engine #(.W(DATA_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && legal),
      .mcand_in  (a_ld),
      .mplier_in (b_ld),
      .fin       (eng_fin),
      .prod      (eng_prod)
   );

   mul_trap_resolve #(.W(DATA_W)) u_resolve (
      .op   (op_q),
      .prod (eng_prod),
      .a    (opa_q),
      .b    (opb_q),
      .res  (fin_res),
      .ovf  (fin_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_BAD;
         opa_q  <= '0;
         opb_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         res_q  <= '0;
         ovf_q  <= 1'b0;
         ill_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            op_q  <= op_d;
            opa_q <= a_ld;
            opb_q <= b_ld;
            if (legal) begin
               busy_q <= 1'b1;
            end else begin
               done_q <= 1'b1;
               res_q  <= '0;
               ovf_q  <= 1'b0;
               ill_q  <= 1'b1;
            end
         end else if (eng_fin) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            res_q  <= fin_res;
            ovf_q  <= fin_ovf;
            ill_q  <= 1'b0;
         end
      end
   end

   assign done   = done_q;
   assign result = res_q;
   assign ovf    = ovf_q;
   assign ill    = ill_q;

endmodule

// File: rtl/mul_trap_chk.sv
module mul_trap_chk
   import mul_trap_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned FUNC_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [FUNC_W-1:0] func,
   input logic              busy_q,
   input logic              eng_fin,
   input mop_e              op_q,
   input logic [DATA_W-1:0] opa_q,
   input logic [DATA_W-1:0] opb_q,
   input logic              done,
   input logic [DATA_W-1:0] result,
   input logic              ovf,
   input logic              ill
);
   logic fn_legal;
   assign fn_legal = (decode_fn(func) != OP_BAD);

   AST_FIN_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_fin |=> (done && !ill)); // R7

   AST_LEGAL_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q && fn_legal) |=> !done); // R7

   AST_ILLEGAL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q && !fn_legal) |=> (done && ill)); // R8

   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ill) |-> (result == '0 && !ovf)); // R8

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !eng_fin) |=> (busy_q && $stable(opa_q) && $stable(opb_q))); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ovf) |-> (op_q == OP_MUL32V || op_q == OP_MUL64V)); // R10

endmodule

bind mul_trap_unit mul_trap_chk #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .func    (func),
   .busy_q  (busy_q),
   .eng_fin (eng_fin),
   .op_q    (op_q),
   .opa_q   (opa_q),
   .opb_q   (opb_q),
   .done    (done),
   .result  (result),
   .ovf     (ovf),
   .ill     (ill)
);

// File: tb/sim_mul_trap_unit.sv
module sim_mul_trap_unit;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 65;
   localparam int WDOG       = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  func = 7'h00;
   logic [63:0] opa = '0, opb = '0;
   logic        done, ovf, ill;
   logic [63:0] result;

   int n_run = 0, n_fail = 0, cycles = 0;
   bit finished = 0;

   mul_trap_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .func(func),
      .opa(opa), .opb(opb), .done(done), .result(result), .ovf(ovf), .ill(ill)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // Expected values straight from the requirement text
   function automatic void expect_of(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                                     output logic [63:0] r, output logic o, output logic bad,
                                     output string tag, output string otag);
      logic signed [63:0]  p64;
      logic [127:0]        u128;
      logic signed [127:0] s128;
      r = '0; o = 1'b0; bad = 1'b0;
      p64 = $signed({{32{a[31]}}, a[31:0]}) * $signed({{32{b[31]}}, b[31:0]});
      case (f)
         7'h00: begin r = {{32{p64[31]}}, p64[31:0]}; tag = "R2"; otag = "R10"; end
         7'h20: begin r = a * b; tag = "R3"; otag = "R10"; end
         7'h30: begin u128 = {64'b0, a} * {64'b0, b}; r = u128[127:64]; tag = "R4"; otag = "R10"; end
         7'h40: begin
            r = {{32{p64[31]}}, p64[31:0]};
            o = !(p64[63:31] == 33'd0 || p64[63:31] == {33{1'b1}});
            tag = "R5"; otag = "R5";
         end
         7'h60: begin
            s128 = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
            r = s128[63:0];
            o = !((s128[127:64] == 64'd0 && !s128[63]) || (s128[127:64] == {64{1'b1}} && s128[63]));
            tag = "R6"; otag = "R6";
         end
         default: begin bad = 1'b1; tag = "R8"; otag = "R8"; end
      endcase
   endfunction

   // Cycle-by-cycle reference model
   int          mcnt = 0;
   logic        m_done = 0, m_ovf = 0, m_ill = 0;
   logic [63:0] m_res = '0;
   string       m_tag = "R1", m_otag = "R1";
   logic [63:0] p_res;
   logic        p_ovf;
   string       p_tag, p_otag;

   always @(posedge clk) begin
      logic [63:0] r;
      logic        o, bad;
      string       t, ot;
      if (!rst_n) begin
         mcnt = 0; m_done = 0; m_res = '0; m_ovf = 0; m_ill = 0;
      end else begin
         m_done = 0;
         if (mcnt > 0) begin
            mcnt--;
            if (mcnt == 0) begin
               m_done = 1; m_res = p_res; m_ovf = p_ovf; m_ill = 0;
               m_tag = p_tag; m_otag = p_otag;
            end
         end else if (start) begin
            expect_of(func, opa, opb, r, o, bad, t, ot);
            if (bad) begin
               m_done = 1; m_res = '0; m_ovf = 0; m_ill = 1; m_tag = "R8"; m_otag = "R8";
            end else begin
               mcnt = LAT; p_res = r; p_ovf = o; p_tag = t; p_otag = ot;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(done === m_done, (mcnt > 0 || !m_ill) ? "R7 done timing" : "R8 done timing",
             {63'b0, done}, {63'b0, m_done});
         if (m_done) begin
            chk(result === m_res, m_tag, result, m_res);
            chk(ovf === m_ovf, m_otag, {63'b0, ovf}, {63'b0, m_ovf});
            chk(ill === m_ill, m_ill ? "R8" : m_tag, {63'b0, ill}, {63'b0, m_ill});
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
         wrap_up();
      end
   end

   task automatic issue(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      start = 1'b1; func = f; opa = a; opb = b;
      @(negedge clk);
      start = 1'b0; func = 7'h00; opa = '1; opb = '1;
   endtask

   task automatic settle();
      while (mcnt != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
      issue(f, a, b);
      settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done === 1'b0 && ovf === 1'b0 && ill === 1'b0, "R1 flags", {61'b0, done, ovf, ill}, 64'd0);
      chk(result === 64'd0, "R1 result", result, 64'd0);

      // R2: junk in the upper operand halves
      run(7'h00, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_0000_0002);
      run(7'h00, 64'hFFFF_0000_FFFF_FFFF, 64'h0000_0001_0000_0003);
      // R3 / R10
      run(7'h20, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
      run(7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
      // R4
      run(7'h30, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
      run(7'h30, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0002);
      // R5 boundaries around bit 31
      run(7'h40, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000);
      run(7'h40, 64'h0000_0000_FFFF_0000, 64'h0000_0000_0000_8000);
      run(7'h40, 64'h0000_0000_FFFF_0000, 64'h0000_0000_0000_7FFF);
      run(7'h40, 64'hAAAA_0000_7FFF_FFFF, 64'h5555_0000_7FFF_FFFF);
      // R6 signed high half
      run(7'h60, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
      run(7'h60, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000);
      run(7'h60, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_8000_0000);
      run(7'h60, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0003);
      run(7'h60, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
      // R8: back-to-back illegal codes
      issue(7'h01, 64'h5, 64'h7);
      issue(7'h7F, 64'h9, 64'h3);
      settle();

      // R9: start while a legal operation runs
      issue(7'h20, 64'd1000, 64'd3);
      repeat (4) @(negedge clk);
      start = 1'b1; func = 7'h7F;
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b0, "R9 busy start ignored", {63'b0, done}, 64'd0);
      while (!done) @(negedge clk);
      chk(result === 64'd3000 && ill === 1'b0, "R9 pending result", result, 64'd3000);
      @(negedge clk);

      // Mixed stream
      for (int i = 0; i < 24; i++) begin
         logic [6:0] f;
         case (i % 6)
            0: f = 7'h00; 1: f = 7'h20; 2: f = 7'h30;
            3: f = 7'h40; 4: f = 7'h60; default: f = 7'h11;
         endcase
         run(f, {$urandom, $urandom}, {$urandom, $urandom});
      end
      repeat (3) @(negedge clk);
      wrap_up();
   end

endmodule